// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes from hardware sources into a 32-bit cause register and drives one level-sensitive interrupt line. Each cause bit is held until software clears it by writing ones to the cause register. A mask register decides which held causes count as pending. The interrupt output is high whenever at least one pending cause exists.

A fixed group of minor causes also sets a summary "other" bit. Software that handles only the summary bit still clears the whole group, because a clear of the summary bit clears every group member. This prevents a masked minor cause from raising the summary bit again after each service pass. An optional auto-mask step removes selected mask bits when software writes the cause register while the interrupt is asserted.

Software reaches the block through a plain single-cycle write strobe with a register select, and a combinational read port with its own select. There is no back-pressure. A write is taken on every clock edge where `wr_en` is high.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause, mask and auto-mask registers read zero and `irq_o` is low.
- R2: A write with select 0 (cause) clears each cause bit written as 1 (new = old AND NOT data) and leaves the other bits unchanged.
- R3: A cause write with data bit 24 set also clears cause bits 2, 6, 9, 16, 17 and 18, even when those data bits are 0.
- R4: Whenever any of cause bits 2, 6, 9, 16, 17 or 18 is set by a hardware event or a cause-set write, cause bit 24 is set in the same update.
- R5: The pending set is cause AND mask over bits 30..0. `irq_o` is high exactly when the pending set is nonzero, and bit 31 of the cause read shows the same value. Bit 31 of hardware events and of cause-set data has no effect.
- R6: A group cause whose own mask bit is 0 still raises `irq_o` through bit 24 when mask bit 24 is 1.
- R7: A cause write made while `irq_o` is high and `automask_en` is 1 clears the mask bits that are set in the auto-mask register. With `irq_o` low or `automask_en` at 0, the mask is unchanged.
- R8: When a hardware event and a cause clear hit the same bit in the same cycle, the bit ends up set.
- R9: A write with select 2 ORs its data into the mask. A write with select 3 clears the mask bits written as 1. A write with select 4 loads the auto-mask register.
- R10: A write with select 1 (cause-set) ORs its data into the cause register.
- R11: `rd_data` shows the cause register for read select 0, the mask for read select 2 and the auto-mask register for read select 4, and 0 for any other select. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_evt | input | DW | One-cycle cause events from hardware sources |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 cause clear, 1 cause set, 2 mask set, 3 mask clear, 4 auto-mask |
| wr_data | input | DW | Write data |
| automask_en | input | 1 | Enables the auto-mask step on cause writes |
| rd_sel | input | 3 | Read target: 0 cause, 2 mask, 4 auto-mask |
| rd_data | output | DW | Read data, combinational |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, summary bit 24 and a group mask of 0x0007_0244. These values place the group, the summary bit and the asserted flag at the positions the requirements name, so the summary set and clear rules are checked bit for bit. Directed steps cover an event arriving in the same cycle as a clear, and a masked group cause that reaches the output only through the summary bit. Sparse random events mixed with random writes then exercise the auto-mask step while the interrupt is both high and low.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  typedef enum logic [2:0] {
    RG_CAUSE     = 3'd0,
    RG_CAUSE_SET = 3'd1,
    RG_MASK_SET  = 3'd2,
    RG_MASK_CLR  = 3'd3,
    RG_AUTOMASK  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int          DW       = 32,
  parameter int          SUM_BIT  = 24,
  parameter logic [31:0] GRP_MASK = 32'h0007_0244
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_raw,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_raw,
  output logic [DW-1:0] cause_q
);
  localparam int FLAG_BIT = DW - 1;
  localparam logic [DW-1:0] GRP = DW'(GRP_MASK);
  localparam logic [DW-1:0] SUM_ONE = DW'(1) << SUM_BIT;

  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  always_comb begin
    set_vec = set_raw;
    if ((set_raw & GRP) != '0) set_vec = set_vec | SUM_ONE;
    clr_vec = '0;
    if (clr_en) begin
      clr_vec = clr_raw;
      if (clr_raw[SUM_BIT]) clr_vec = clr_vec | GRP;
    end
  end

  // Per-bit hold cell: a set in the same cycle as a clear wins.
  for (genvar i = 0; i < FLAG_BIT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) cause_q[i] <= 1'b0;
      else     cause_q[i] <= set_vec[i] | (cause_q[i] & ~clr_vec[i]);
    end
  end
  assign cause_q[FLAG_BIT] = 1'b0;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((cause_q & $past(clr_raw) & ~$past(set_vec)) == '0)); // R2
  AST_SUMMARY_CLR: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_raw[SUM_BIT] && ((set_raw & GRP) == '0)) |=> ((cause_q & GRP) == '0)); // R3
  AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (rst)
    ((set_raw & GRP) != '0) |=> cause_q[SUM_BIT]); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_raw != '0) |=> ((cause_q & $past(set_raw)) == $past(set_raw))); // R8
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic          am_wr,
  input  logic          am_fire,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] am_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      am_q   <= '0;
    end else begin
      if (set_en)       mask_q <= mask_q | data;
      else if (clr_en)  mask_q <= mask_q & ~data;
      else if (am_fire) mask_q <= mask_q & ~am_q;
      if (am_wr) am_q <= data;
    end
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mask_q & $past(data)) == $past(data))); // R9
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((mask_q & $past(data)) == '0)); // R9
  AST_AUTOMASK: assert property (@(posedge clk) disable iff (rst)
    am_fire |=> ((mask_q & $past(am_q)) == '0)); // R7
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cause_q,
  input  logic [DW-1:0] mask_q,
  output logic          flag
);
  localparam logic [DW-1:0] LOW_BITS = {1'b0, {(DW-1){1'b1}}};
  logic [DW-1:0] pend;
  assign pend = cause_q & mask_q & LOW_BITS;
  assign flag = |pend;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          SUM_BIT  = 24,
  parameter logic [31:0] GRP_MASK = 32'h0007_0244
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] hw_evt,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          automask_en,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  localparam int FLAG_BIT = DW - 1;
  localparam logic [DW-1:0] LOW_BITS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] cause_q, mask_q, am_q, set_raw, cause_view;
  logic          wr_cause, wr_cset, wr_mset, wr_mclr, wr_am, am_fire, flag;

  assign wr_cause = wr_en && (wr_sel == RG_CAUSE);
  assign wr_cset  = wr_en && (wr_sel == RG_CAUSE_SET);
  assign wr_mset  = wr_en && (wr_sel == RG_MASK_SET);
  assign wr_mclr  = wr_en && (wr_sel == RG_MASK_CLR);
  assign wr_am    = wr_en && (wr_sel == RG_AUTOMASK);

  assign set_raw = (hw_evt | (wr_cset ? wr_data : '0)) & LOW_BITS;
  assign am_fire = wr_cause && flag && automask_en;

  irq_cause_bank #(.DW(DW), .SUM_BIT(SUM_BIT), .GRP_MASK(GRP_MASK)) u_cause (
    .clk(clk), .rst(rst), .set_raw(set_raw), .clr_en(wr_cause),
    .clr_raw(wr_data), .cause_q(cause_q)
  );

  irq_mask_bank #(.DW(DW)) u_mask (
    .clk(clk), .rst(rst), .set_en(wr_mset), .clr_en(wr_mclr), .am_wr(wr_am),
    .am_fire(am_fire), .data(wr_data), .mask_q(mask_q), .am_q(am_q)
  );

  irq_pend_eval #(.DW(DW)) u_pend (
    .cause_q(cause_q), .mask_q(mask_q), .flag(flag)
  );

  always_comb begin
    cause_view = cause_q;
    cause_view[FLAG_BIT] = flag;
    case (rd_sel)
      RG_CAUSE:    rd_data = cause_view;
      RG_MASK_SET: rd_data = mask_q;
      RG_AUTOMASK: rd_data = am_q;
      default:     rd_data = '0;
    endcase
  end
  assign irq_o = flag;

  AST_NO_AUTOMASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_cause && !(flag && automask_en)) |=> $stable(mask_q)); // R7
  AST_FLAG_SET_ONLY_BY_PEND: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ((cause_q & mask_q & LOW_BITS) != '0)); // R5
endmodule

// File: tb/irq_cause_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cause_ctrl_bench;
  localparam int DW = 32;
  localparam logic [31:0] GRP = 32'h0007_0244;
  localparam logic [31:0] SUMB = 32'h0100_0000;
  localparam logic [31:0] LOW = 32'h7FFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] hw_evt = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic automask_en = 1'b0;
  logic [2:0] rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic irq_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] m_cause = '0, m_mask = '0, m_am = '0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl u_irq_cause_ctrl (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .automask_en(automask_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic m_flag();
    return (m_cause & m_mask & LOW) != 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare every visible register plus the output against the model.
  task automatic compare(input string tag);
    chk(tag, "irq_o", {31'd0, irq_o}, {31'd0, m_flag()});
    rd_sel = 3'd0; #0.2;
    chk(tag, "cause", rd_data, m_cause | (m_flag() ? 32'h8000_0000 : 32'h0));
    rd_sel = 3'd2; #0.2;
    chk(tag, "mask", rd_data, m_mask);
    rd_sel = 3'd4; #0.2;
    chk(tag, "automask", rd_data, m_am);
    rd_sel = 3'd5; #0.2;
    chk(tag, "unused", rd_data, 32'h0);
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge.
  task automatic step(input string tag, input logic en, input logic [2:0] sel,
                      input logic [31:0] data, input logic [31:0] evt, input logic am_en);
    logic [31:0] sets, clr;
    logic fl;
    wr_en = en; wr_sel = sel; wr_data = data; hw_evt = evt; automask_en = am_en;
    @(posedge clk);
    fl = m_flag();
    sets = evt & LOW;
    if (en && sel == 3'd1) sets = sets | (data & LOW);
    if ((sets & GRP) != 0) sets = sets | SUMB;
    clr = 0;
    if (en && sel == 3'd0) begin
      clr = data;
      if (data[24]) clr = clr | GRP;
      if (fl && am_en) m_mask = m_mask & ~m_am;
    end
    m_cause = ((m_cause & ~clr) | sets) & LOW;
    if (en && sel == 3'd2) m_mask = m_mask | data;
    if (en && sel == 3'd3) m_mask = m_mask & ~data;
    if (en && sel == 3'd4) m_am = data;
    @(negedge clk);
    wr_en = 1'b0; hw_evt = '0;
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
    // R9 mask set and clear
    step("R9", 1, 3'd2, 32'h0100_0004, 0, 0);
    step("R9", 1, 3'd3, 32'h0000_0004, 0, 0);
    // R6 and R4: masked bit 6 raises irq through bit 24
    step("R6", 0, 3'd0, 0, 32'h0000_0040, 0);
    // R11 reads have no side effect
    step("R11", 0, 3'd0, 0, 0, 0);
    step("R11", 0, 3'd0, 0, 0, 0);
    // R3 clearing the summary clears bit 6
    step("R3", 1, 3'd0, 32'h0100_0000, 0, 0);
    // R10 cause-set, with and without a group member
    step("R10", 1, 3'd1, 32'h0000_0001, 0, 0);
    step("R4", 1, 3'd1, 32'h0002_0000, 0, 0);
    // R2 write-one-to-clear touches only bit 0
    step("R2", 1, 3'd0, 32'h0000_0001, 0, 0);
    // R7 auto-mask fires while irq is high
    step("R9", 1, 3'd4, 32'h0100_0000, 0, 0);
    step("R7", 1, 3'd0, 32'h0000_0000, 0, 1);
    step("R7", 1, 3'd2, 32'h0100_0000, 0, 0);
    step("R7", 1, 3'd0, 32'h0000_0000, 0, 0);
    step("R3", 1, 3'd0, 32'h0100_0000, 0, 1);
    step("R7", 1, 3'd0, 32'h0000_0000, 0, 1);
    // R8 event and clear on bit 5 in one cycle
    step("R8", 1, 3'd0, 32'h0000_0020, 32'h0000_0020, 0);
    // R5 pending via bit 5, and bit 31 events ignored
    step("R5", 1, 3'd2, 32'h0000_0020, 0, 0);
    step("R5", 1, 3'd0, 32'h0000_0020, 32'h8000_0000, 0);
    step("R5", 1, 3'd1, 32'h8000_0000, 0, 0);
    for (int i = 0; i < 400; i++) begin
      step("RND", ($urandom % 3) != 0, 3'($urandom % 6), $urandom & $urandom,
           $urandom & $urandom & $urandom & $urandom, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule